// File: doc/BRIEF.md
# Chip-Select Watchdog Reset Supervisor

This block drives a system reset from two causes. A supply-good input, standing in for an undervoltage comparator, holds reset asserted while the supply is low. Once the supply recovers, reset stays asserted for a fixed hold period. A watchdog watches a chip-select line and raises the same reset when that line does not fall within a chosen window.

All durations are counted in pulses of a `tick_i` time base, for example one pulse per millisecond. The counts are set by parameters. A 2-bit selector picks one of three watchdog windows or turns the watchdog off. The reset level is set by a parameter. A separate active-low enable drives an external open-drain pull-down.

Top module: `cs_wdt_supervisor`

## Requirements
- R1: While `rst_ni` is low, reset is asserted. After `rst_ni` rises, reset is released on the (HOLD_TICKS+4)th rising clock edge, with ticks present on every cycle and the supply good. This count is two edges of reset release, two edges of supply synchronisation and the hold.
- R2: `supply_ok_i` passes through a two-flop synchroniser. When it goes low, reset is asserted on the second rising edge and not on the first.
- R3: When the synchronised supply returns high, reset stays asserted for exactly HOLD_TICKS counted ticks. A new dip during the hold restarts the full hold.
- R4: The hold and watchdog counters advance only on cycles where `tick_i` is high. With `tick_i` held low, reset is never released.
- R5: `wdt_sel_i` encodings are 2'b00 for WD_LONG_TICKS, 2'b01 for WD_MID_TICKS and 2'b10 for WD_SHORT_TICKS. If chip select stays at one level, reset asserts exactly that many ticks after the watchdog window starts.
- R6: `wdt_sel_i` = 2'b11 disables the watchdog, so reset never asserts from it.
- R7: A falling edge on `cs_n_i` restarts the watchdog window. The window runs again from zero and can then expire with chip select held low.
- R8: A rising edge on `cs_n_i` does not restart the watchdog window.
- R9: A watchdog reset lasts exactly HOLD_TICKS ticks. The watchdog window restarts from zero when that reset ends.
- R10: With ACTIVE_HIGH = 0, `rst_o` is low while reset is asserted. With ACTIVE_HIGH = 1, it is high. `rst_oe_n_o` is low exactly while reset is asserted, for either polarity.
- R11: The watchdog does not count while reset is asserted, so a window always starts fresh when reset ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | Time-base pulse that advances all counters |
| supply_ok_i | input | 1 | Asynchronous supply-good flag, high when the supply is above threshold |
| cs_n_i | input | 1 | Active-low chip select being monitored |
| wdt_sel_i | input | 2 | Watchdog window select: 00 long, 01 mid, 10 short, 11 off |
| rst_o | output | 1 | Reset output, level set by ACTIVE_HIGH |
| rst_oe_n_o | output | 1 | Active-low pull-down enable for an open-drain reset pin |

## Verification
On every cycle, the assertions check the following:
- a disabled watchdog and a watchdog under reset never fire;
- a falling chip-select edge clears the window count;
- the hold counter stays inside its range;
- reset is released only with the supply good and on a tick;
- a watchdog trip always starts a fresh hold.

Some behaviour can only be shown by the bench's scenarios, which time each release and trip to the exact edge. This covers the exact lengths of the hold and of each selected window, a rising chip-select edge being ignored, a repeated dip restarting the hold, a stalled tick freezing the counters, and the two output polarities.

// File: rtl/cswd_pkg.sv
package cswd_pkg;
  typedef enum logic [1:0] {
    WD_LONG  = 2'b00,
    WD_MID   = 2'b01,
    WD_SHORT = 2'b10,
    WD_OFF   = 2'b11
  } wd_sel_e;
endpackage

// File: rtl/cswd_sync2.sv
module cswd_sync2 #(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= RESET_VAL;
      stage2_q <= RESET_VAL;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/cswd_hold.sv
module cswd_hold #(
  parameter int HOLD_TICKS = 200
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic supply_ok_i,
  input  logic trip_i,
  output logic active_o
);
  localparam int CNT_W = $clog2(HOLD_TICKS + 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_TICKS - 1);

  logic             in_reset_q, in_reset_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             restart;

  assign restart = !supply_ok_i || trip_i;

  always_comb begin
    in_reset_d = in_reset_q;
    cnt_d      = cnt_q;
    if (restart) begin
      in_reset_d = 1'b1;
      cnt_d      = '0;
    end else if (in_reset_q && tick_i) begin
      if (cnt_q == HOLD_LAST) begin
        in_reset_d = 1'b0;
        cnt_d      = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      in_reset_q <= 1'b1;
      cnt_q      <= '0;
    end else begin
      in_reset_q <= in_reset_d;
      cnt_q      <= cnt_d;
    end
  end

  assign active_o = in_reset_q || !supply_ok_i;

  // R3
  hold_release_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(in_reset_q) |-> (supply_ok_i && $past(tick_i)));
  // R3
  hold_bound_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q <= HOLD_LAST);
  // R9
  trip_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $past(trip_i) |-> (active_o && cnt_q == '0));
endmodule

// File: rtl/cswd_watchdog.sv
module cswd_watchdog
  import cswd_pkg::*;
#(
  parameter int LONG_TICKS  = 1400,
  parameter int MID_TICKS   = 600,
  parameter int SHORT_TICKS = 200
) (
  input  logic    clk,
  input  logic    rst_ni,
  input  logic    tick_i,
  input  logic    cs_n_i,
  input  wd_sel_e sel_i,
  input  logic    hold_i,
  output logic    expire_o
);
  localparam int MAX_TICKS = (LONG_TICKS > MID_TICKS)
                           ? ((LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS)
                           : ((MID_TICKS > SHORT_TICKS) ? MID_TICKS : SHORT_TICKS);
  localparam int CNT_W = $clog2(MAX_TICKS + 1);

  logic             cs_q, cs_prev_q;
  logic             cs_fall;
  logic             enabled;
  logic [CNT_W-1:0] last_cnt;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q      <= 1'b1;
      cs_prev_q <= 1'b1;
    end else begin
      cs_q      <= cs_n_i;
      cs_prev_q <= cs_q;
    end
  end

  assign cs_fall = cs_prev_q && !cs_q;

  always_comb begin
    case (sel_i)
      WD_LONG:  last_cnt = CNT_W'(LONG_TICKS - 1);
      WD_MID:   last_cnt = CNT_W'(MID_TICKS - 1);
      WD_SHORT: last_cnt = CNT_W'(SHORT_TICKS - 1);
      default:  last_cnt = '0;
    endcase
  end

  assign enabled  = (sel_i != WD_OFF) && !hold_i;
  assign expire_o = enabled && tick_i && !cs_fall && (cnt_q >= last_cnt);

  always_comb begin
    cnt_d = cnt_q;
    if (!enabled || cs_fall || expire_o) begin
      cnt_d = '0;
    end else if (tick_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R6
  off_silent_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (sel_i == WD_OFF) |-> !expire_o);
  // R11
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    hold_i |-> !expire_o);
  // R7
  kick_clear_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $past(cs_fall) |-> (cnt_q == '0));
  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    cnt_q < CNT_W'(MAX_TICKS));
endmodule

// File: rtl/cs_wdt_supervisor.sv
module cs_wdt_supervisor
  import cswd_pkg::*;
#(
  parameter int HOLD_TICKS     = 200,
  parameter int WD_LONG_TICKS  = 1400,
  parameter int WD_MID_TICKS   = 600,
  parameter int WD_SHORT_TICKS = 200,
  parameter bit ACTIVE_HIGH    = 1'b0
) (
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       supply_ok_i,
  input  logic       cs_n_i,
  input  logic [1:0] wdt_sel_i,
  output logic       rst_o,
  output logic       rst_oe_n_o
);
  logic int_rst_n;
  logic supply_sync;
  logic wd_expire;
  logic rst_active;

  cswd_sync2 #(.RESET_VAL(1'b0)) u_rst_sync (
    .clk    (clk),
    .rst_ni (rst_ni),
    .d_i    (1'b1),
    .q_o    (int_rst_n)
  );

  cswd_sync2 #(.RESET_VAL(1'b0)) u_supply_sync (
    .clk    (clk),
    .rst_ni (int_rst_n),
    .d_i    (supply_ok_i),
    .q_o    (supply_sync)
  );

  cswd_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
    .clk         (clk),
    .rst_ni      (int_rst_n),
    .tick_i      (tick_i),
    .supply_ok_i (supply_sync),
    .trip_i      (wd_expire),
    .active_o    (rst_active)
  );

  cswd_watchdog #(
    .LONG_TICKS  (WD_LONG_TICKS),
    .MID_TICKS   (WD_MID_TICKS),
    .SHORT_TICKS (WD_SHORT_TICKS)
  ) u_wdt (
    .clk      (clk),
    .rst_ni   (int_rst_n),
    .tick_i   (tick_i),
    .cs_n_i   (cs_n_i),
    .sel_i    (wd_sel_e'(wdt_sel_i)),
    .hold_i   (rst_active),
    .expire_o (wd_expire)
  );

  generate
    if (ACTIVE_HIGH) begin : g_pol_high
      assign rst_o = rst_active;
    end else begin : g_pol_low
      assign rst_o = !rst_active;
    end
  endgenerate

  assign rst_oe_n_o = !rst_active;

  // R2
  supply_low_chk: assert property (@(posedge clk) disable iff (!int_rst_n)
    !supply_sync |-> !rst_oe_n_o);
endmodule

// File: tb/cs_wdt_supervisor_bench.sv
`timescale 1ns/100ps
module cs_wdt_supervisor_bench;
  localparam int HOLD  = 5;
  localparam int LONG  = 20;
  localparam int MID   = 12;
  localparam int SHORT = 7;

  logic       clk = 1'b0;
  logic       rst_ni, tick, supply_ok, cs_n;
  logic [1:0] sel;
  logic       rst_lo, oe_lo, rst_hi, oe_hi;
  int         checks = 0;
  int         errors = 0;

  always #2.5 clk = ~clk;

  cs_wdt_supervisor #(.HOLD_TICKS(HOLD), .WD_LONG_TICKS(LONG), .WD_MID_TICKS(MID),
    .WD_SHORT_TICKS(SHORT), .ACTIVE_HIGH(1'b0)) u_cs_wdt_supervisor (
    .clk(clk), .rst_ni(rst_ni), .tick_i(tick), .supply_ok_i(supply_ok),
    .cs_n_i(cs_n), .wdt_sel_i(sel), .rst_o(rst_lo), .rst_oe_n_o(oe_lo));

  cs_wdt_supervisor #(.HOLD_TICKS(HOLD), .WD_LONG_TICKS(LONG), .WD_MID_TICKS(MID),
    .WD_SHORT_TICKS(SHORT), .ACTIVE_HIGH(1'b1)) u_cs_wdt_supervisor_hi (
    .clk(clk), .rst_ni(rst_ni), .tick_i(tick), .supply_ok_i(supply_ok),
    .cs_n_i(cs_n), .wdt_sel_i(sel), .rst_o(rst_hi), .rst_oe_n_o(oe_hi));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // exp = 1 means reset asserted; R10 polarity is checked on every call
  task automatic expect_rst(input logic exp, input string req);
    checks++;
    if (rst_lo !== ~exp || oe_lo !== ~exp || rst_hi !== exp || oe_hi !== ~exp) begin
      errors++;
      $display("FAIL %s (R10 outputs): lo=%b oe=%b hi=%b oe_hi=%b expected asserted=%b",
               req, rst_lo, oe_lo, rst_hi, oe_hi, exp);
    end
  endtask

  task automatic recover(input string req);
    step(HOLD - 1); expect_rst(1'b1, req);
    step(1);        expect_rst(1'b0, req);
  endtask

  task automatic t_reset;
    rst_ni = 1'b0; tick = 1'b1; supply_ok = 1'b1; cs_n = 1'b1; sel = 2'b00;
    step(3); expect_rst(1'b1, "R1 in reset");
    rst_ni = 1'b1;
    step(HOLD + 3); expect_rst(1'b1, "R1 before release");
    step(1);        expect_rst(1'b0, "R1 release");
  endtask

  task automatic t_long_high;
    step(LONG - 1); expect_rst(1'b0, "R5 long not yet");
    step(1);        expect_rst(1'b1, "R5 long expiry");
    recover("R9 trip hold");
  endtask

  task automatic t_kick;
    step(LONG - 2); cs_n = 1'b0;
    step(1);
    step(LONG); expect_rst(1'b0, "R7 kick extends");
    step(1);    expect_rst(1'b1, "R7 steady low expiry");
    recover("R9 trip hold");
  endtask

  task automatic t_rise;
    step(LONG - 3); cs_n = 1'b1;
    step(2); expect_rst(1'b0, "R8 before expiry");
    step(1); expect_rst(1'b1, "R8 rise ignored");
    recover("R9 trip hold");
  endtask

  task automatic t_sel(input logic [1:0] code, input int lim, input string req);
    sel = code;
    step(lim - 1); expect_rst(1'b0, req);
    step(1);       expect_rst(1'b1, req);
    recover("R9 trip hold");
  endtask

  task automatic t_off;
    sel = 2'b11;
    step(3 * LONG); expect_rst(1'b0, "R6 disabled");
  endtask

  task automatic t_supply;
    supply_ok = 1'b0;
    step(1); expect_rst(1'b0, "R2 one edge");
    step(1); expect_rst(1'b1, "R2 two edges");
    step(3); supply_ok = 1'b1;
    step(4); supply_ok = 1'b0;
    step(3); supply_ok = 1'b1;
    step(HOLD + 1); expect_rst(1'b1, "R3 dip restart");
    step(1);        expect_rst(1'b0, "R3 hold end");
  endtask

  task automatic t_tick;
    supply_ok = 1'b0; step(4);
    supply_ok = 1'b1; tick = 1'b0; sel = 2'b10;
    step(30); expect_rst(1'b1, "R4 frozen without tick");
    tick = 1'b1;
    recover("R4 resumes");
    step(SHORT - 1); expect_rst(1'b0, "R11 fresh window");
    step(1);         expect_rst(1'b1, "R11 expiry");
    recover("R9 trip hold");
  endtask

  initial begin
    t_reset();
    t_long_high();
    t_kick();
    t_rise();
    t_sel(2'b01, MID, "R5 mid");
    t_sel(2'b10, SHORT, "R5 short");
    t_sel(2'b00, LONG, "R5 long");
    t_off();
    t_supply();
    t_tick();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule